// File: doc/BRIEF.md
# Shared Word Memory with Linked-Load Reservations

This block is a small word-addressed memory shared by several requester ports (two by default). Each port can issue four kinds of request: a plain read, a plain write, a linked read, and a conditional write. A linked read returns the word like a plain read. It also records a reservation for that port on that address. A conditional write stores its data only while that port's reservation is still intact, and it answers with a result word of 1 (written) or 0 (refused). Software builds test-and-set locks and atomic swaps from this pair of operations. A lock is released with an ordinary write of zero.

Each port holds one reservation: a valid flag and an address. Any write that lands on a reserved address cancels that reservation, whichever port owns it. This covers plain writes and successful conditional writes from any port. A port's own conditional write always cancels its reservation, whether or not it succeeds. Only one request is accepted per cycle. The lowest-numbered port that is requesting wins. Each accepted request gets its response one cycle later, marked by a per-port response strobe on a shared response data bus.

Top module: `atomic_word_store`

## Requirements
- R1: The operation code has four values: 0 = plain read, 1 = plain write, 2 = linked read, 3 = conditional write. A plain read accepted at a clock edge returns the addressed word on `rsp_data` at the next edge, with `rsp_valid` high only for the requesting port.
- R2: A plain write stores its data unconditionally, including a write of zero to a lock word, and returns 0 as its response.
- R3: A linked read returns the addressed word exactly as a plain read does, and records a reservation for the requesting port on that address.
- R4: A conditional write whose port holds a valid reservation on the same address stores its data and returns 1.
- R5: A conditional write issued with no valid reservation, or to an address other than the reserved one, leaves memory unchanged and returns 0.
- R6: Any write to a reserved address clears that reservation, whichever port wrote. This includes another port's successful conditional write.
- R7: A completed conditional write clears its own port's reservation, whether it succeeded or failed.
- R8: A new linked read from a port replaces that port's previous reservation.
- R9: When several ports request in the same cycle, the lowest-numbered one is accepted and the others see `req_ready` low. A port-0 write to an address that port 1 has reserved therefore clears the reservation before port 1's pending conditional write is evaluated.
- R10: After reset all words read as zero, no reservation is held, and no `rsp_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NPORTS | Request valid, one bit per port |
| req_ready | output | NPORTS | Request accepted this cycle, one bit per port |
| req_op | input | 2*NPORTS | Operation code per port (2 bits each) |
| req_addr | input | ADDR_W*NPORTS | Word address per port |
| req_wdata | input | DATA_W*NPORTS | Write data per port |
| rsp_valid | output | NPORTS | Response strobe, one cycle after acceptance |
| rsp_data | output | DATA_W | Read word, or 1/0 conditional result, or 0 for a plain write |

## Verification
The assertions assume that a request's fields stay stable while its valid bit is high and ready is low. They also assume that operation codes are always one of the four defined values. The bench meets both assumptions. It drives every field away from the clock edge and keeps it constant until acceptance. The only time it holds a request across a refused cycle is the contention scenario, where port 1's conditional write waits unchanged behind port 0's write.

// File: rtl/atomic_pkg.sv
// Package: shared operation encoding for the reservation memory.
// Assumes two-bit operation codes on every request port.
package atomic_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } mem_op_e;
endpackage

// File: rtl/fixed_prio_arb.sv
// Fixed-priority arbiter: the lowest-index requester wins.
// Assumes requests may change every cycle; the grant is purely combinational.
module fixed_prio_arb #(
    parameter int NREQ = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] ready,
    output logic [NREQ-1:0] grant
);
    logic [NREQ:0] blocked;

    assign blocked[0] = 1'b0;

    // Chain of "a lower-index port is requesting" flags.
    for (genvar i = 0; i < NREQ; i++) begin : g_chain
        assign blocked[i+1] = blocked[i] | req[i];
        assign ready[i]     = ~blocked[i];
        assign grant[i]     = req[i] & ~blocked[i];
    end

    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_port0_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> (grant == NREQ'(1)));
endmodule

// File: rtl/resv_tracker.sv
// Per-port reservation register: a valid flag plus the reserved address.
// Assumes at most one of link_set and cond_done is high in a cycle.
module resv_tracker #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_set,
    input  logic [ADDR_W-1:0] link_addr,
    input  logic              cond_done,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              resv_valid,
    output logic [ADDR_W-1:0] resv_addr
);
    // Set on a linked read, drop on own conditional write or a write to the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_valid <= 1'b0;
            resv_addr  <= '0;
        end else if (link_set) begin
            resv_valid <= 1'b1;
            resv_addr  <= link_addr;
        end else if (cond_done) begin
            resv_valid <= 1'b0;
        end else if (wr_en && (wr_addr == resv_addr)) begin
            resv_valid <= 1'b0;
        end
    end

    assert_write_kills_resv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && resv_valid && (wr_addr == resv_addr) && !link_set) |=> !resv_valid);
    assert_cond_clears_own_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_done && !link_set) |=> !resv_valid);
    assert_link_replaces_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_set |=> (resv_valid && (resv_addr == $past(link_addr))));
endmodule

// File: rtl/word_bank.sv
// Word storage: one write port, one combinational read port, cleared by reset.
// Assumes read and write of the same word in a cycle returns the old word.
module word_bank #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear all words on reset, otherwise perform the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/atomic_word_store.sv
// Shared word memory with per-port linked-read reservations and conditional writes.
// One request is accepted per cycle (lowest port first); the response follows one cycle later.
// Assumes request fields are held stable while valid is high and ready is low.
module atomic_word_store
    import atomic_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS-1:0]        req_valid,
    output logic [NPORTS-1:0]        req_ready,
    input  logic [2*NPORTS-1:0]      req_op,
    input  logic [ADDR_W*NPORTS-1:0] req_addr,
    input  logic [DATA_W*NPORTS-1:0] req_wdata,
    output logic [NPORTS-1:0]        rsp_valid,
    output logic [DATA_W-1:0]        rsp_data
);
    logic [NPORTS-1:0] grant;
    logic              acc;
    mem_op_e           sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic [NPORTS-1:0] resv_valid;
    logic [ADDR_W-1:0] resv_addr [NPORTS];
    logic              sc_ok;
    logic              wr_en;
    logic [DATA_W-1:0] rd_word;

    fixed_prio_arb #(.NREQ(NPORTS)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_valid),
        .ready (req_ready),
        .grant (grant)
    );

    // Route the granted port's request fields to the shared datapath.
    always_comb begin
        acc       = |grant;
        sel_op    = OP_READ;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (grant[i]) begin
                sel_op    = mem_op_e'(req_op[2*i +: 2]);
                sel_addr  = req_addr[ADDR_W*i +: ADDR_W];
                sel_wdata = req_wdata[DATA_W*i +: DATA_W];
            end
        end
    end

    // Conditional-write decision from the granted port's reservation.
    always_comb begin
        sc_ok = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (grant[i] && resv_valid[i] && (resv_addr[i] == sel_addr)) sc_ok = 1'b1;
        end
        wr_en = acc && ((sel_op == OP_WRITE) || ((sel_op == OP_COND) && sc_ok));
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_resv
        resv_tracker #(.ADDR_W(ADDR_W)) u_resv (
            .clk        (clk),
            .rst_n      (rst_n),
            .link_set   (grant[p] && (sel_op == OP_LINK)),
            .link_addr  (sel_addr),
            .cond_done  (grant[p] && (sel_op == OP_COND)),
            .wr_en      (wr_en),
            .wr_addr    (sel_addr),
            .resv_valid (resv_valid[p]),
            .resv_addr  (resv_addr[p])
        );

        assert_rsp_follows_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
            grant[p] |=> rsp_valid[p]);
    end

    word_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (sel_addr),
        .wdata (sel_wdata),
        .raddr (sel_addr),
        .rdata (rd_word)
    );

    // Register the response one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= grant;
            unique case (sel_op)
                OP_READ, OP_LINK: rsp_data <= rd_word;
                OP_COND:          rsp_data <= DATA_W'(sc_ok);
                default:          rsp_data <= '0;
            endcase
        end
    end

    assert_cond_success_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (sel_op == OP_COND) && sc_ok) |=>
            ((u_bank.mem[$past(sel_addr)] == $past(sel_wdata)) && (rsp_data == DATA_W'(1))));
    assert_cond_fail_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (sel_op == OP_COND) && !sc_ok) |=>
            ((u_bank.mem[$past(sel_addr)] == $past(u_bank.mem[sel_addr])) && (rsp_data == '0)));
    assert_plain_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (sel_op == OP_WRITE)) |=> (u_bank.mem[$past(sel_addr)] == $past(sel_wdata)));
    assert_rsp_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));
endmodule

// File: tb/atomic_word_store_tb.sv
// Directed bench for the reservation memory: one task per scenario.
module atomic_word_store_tb;
    localparam int NP = 2;
    localparam int DW = 32;
    localparam int AW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     req_valid = '0;
    logic [NP-1:0]     req_ready;
    logic [2*NP-1:0]   req_op = '0;
    logic [AW*NP-1:0]  req_addr = '0;
    logic [DW*NP-1:0]  req_wdata = '0;
    logic [NP-1:0]     rsp_valid;
    logic [DW-1:0]     rsp_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    atomic_word_store #(.NPORTS(NP), .DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic put_req(input int p, input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid[p]          = 1'b1;
        req_op[2*p +: 2]      = op;
        req_addr[AW*p +: AW]  = a;
        req_wdata[DW*p +: DW] = d;
    endtask

    // Single request from one port; returns the response word.
    task automatic access(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] r);
        @(negedge clk);
        put_req(p, op, a, d);
        @(negedge clk);
        req_valid = '0;
        check("R1 response strobe", {30'd0, rsp_valid}, 32'(1 << p));
        r = rsp_data;
    endtask

    task automatic t_reset;
        logic [DW-1:0] r;
        check("R10 no rsp after reset", {30'd0, rsp_valid}, 32'd0);
        access(0, 2'd0, 4'd5, '0, r);
        check("R10 word cleared", r, 32'd0);
    endtask

    task automatic t_plain;
        logic [DW-1:0] r;
        access(0, 2'd1, 4'd3, 32'hA5A5_0001, r);
        check("R2 write rsp zero", r, 32'd0);
        access(1, 2'd0, 4'd3, '0, r);
        check("R1 read back", r, 32'hA5A5_0001);
    endtask

    task automatic t_link_cond_ok;
        logic [DW-1:0] r;
        access(1, 2'd2, 4'd3, '0, r);
        check("R3 linked read data", r, 32'hA5A5_0001);
        access(1, 2'd3, 4'd3, 32'h1111, r);
        check("R4 cond success", r, 32'd1);
        access(0, 2'd0, 4'd3, '0, r);
        check("R4 cond stored", r, 32'h1111);
        access(1, 2'd3, 4'd3, 32'h2222, r);
        check("R7 reservation gone after success", r, 32'd0);
        access(0, 2'd0, 4'd3, '0, r);
        check("R5 failed cond no write", r, 32'h1111);
    endtask

    task automatic t_wrong_addr;
        logic [DW-1:0] r;
        access(0, 2'd2, 4'd4, '0, r);
        access(0, 2'd3, 4'd6, 32'h6666, r);
        check("R5 cond other address fails", r, 32'd0);
        access(0, 2'd0, 4'd6, '0, r);
        check("R5 other address untouched", r, 32'd0);
        access(0, 2'd3, 4'd4, 32'h4444, r);
        check("R7 reservation gone after failure", r, 32'd0);
    endtask

    task automatic t_intervening;
        logic [DW-1:0] r;
        access(0, 2'd2, 4'd7, '0, r);
        access(1, 2'd1, 4'd7, 32'h0, r);
        access(0, 2'd3, 4'd7, 32'h9, r);
        check("R6 plain write kills resv", r, 32'd0);
        access(0, 2'd0, 4'd7, '0, r);
        check("R6 memory kept other write", r, 32'd0);
        access(0, 2'd2, 4'd8, '0, r);
        access(1, 2'd2, 4'd8, '0, r);
        access(1, 2'd3, 4'd8, 32'h88, r);
        check("R6 first cond wins", r, 32'd1);
        access(0, 2'd3, 4'd8, 32'h99, r);
        check("R6 other cond kills resv", r, 32'd0);
        access(1, 2'd0, 4'd8, '0, r);
        check("R6 winner data kept", r, 32'h88);
    endtask

    task automatic t_replace;
        logic [DW-1:0] r;
        access(0, 2'd2, 4'd9, '0, r);
        access(0, 2'd2, 4'd10, '0, r);
        access(0, 2'd3, 4'd9, 32'h9, r);
        check("R8 old reservation replaced", r, 32'd0);
        access(0, 2'd2, 4'd9, '0, r);
        access(0, 2'd2, 4'd10, '0, r);
        access(0, 2'd3, 4'd10, 32'hA, r);
        check("R8 new reservation used", r, 32'd1);
    endtask

    task automatic t_mutex;
        logic [DW-1:0] r;
        access(0, 2'd2, 4'd2, '0, r);
        check("R3 lock free", r, 32'd0);
        access(0, 2'd3, 4'd2, 32'd1, r);
        check("R4 lock taken", r, 32'd1);
        access(1, 2'd2, 4'd2, '0, r);
        check("R3 lock seen held", r, 32'd1);
        access(0, 2'd1, 4'd2, 32'd0, r);
        access(1, 2'd0, 4'd2, '0, r);
        check("R2 release by zero write", r, 32'd0);
    endtask

    task automatic t_priority;
        logic [DW-1:0] r;
        access(1, 2'd2, 4'd12, '0, r);
        @(negedge clk);
        put_req(0, 2'd1, 4'd12, 32'h55);
        put_req(1, 2'd3, 4'd12, 32'h77);
        #1;
        check("R9 port1 held off", {31'd0, req_ready[1]}, 32'd0);
        check("R9 port0 ready", {31'd0, req_ready[0]}, 32'd1);
        @(negedge clk);
        req_valid[0] = 1'b0;
        check("R9 port0 served first", {30'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        req_valid = '0;
        check("R9 port1 served next", {30'd0, rsp_valid}, 32'd2);
        check("R9 port1 cond fails", rsp_data, 32'd0);
        access(0, 2'd0, 4'd12, '0, r);
        check("R9 port0 data stands", r, 32'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_link_cond_ok();
        t_wrong_addr();
        t_intervening();
        t_replace();
        t_mutex();
        t_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule